// File: doc/BRIEF.md
# ADC Peak Level Meter

This block watches the stream of signed ADC samples and keeps the loudest level seen since tracking was switched on. It does not store a linear maximum. It stores a 6-bit attenuation code in whole-decibel steps below full scale: 0 means full scale and 63 means 63 dB down or quieter. A level meter or gain-setting routine reads this code through a register-style read port, using address 5 and data bits 5:0.

Tracking runs only while the enable input is high. Reading the peak address returns the held code and also clears it, so the next read reports the loudest level since the previous read. Tracking continues without a break across each read. The threshold for each decibel step is worked out when the design is elaborated, so no table is written out in the source.

Top module: `adc_peak_meter`

## Requirements
- R1: A sample of magnitude m maps to the smallest k in 0..62 for which m >= ceil(FS * 10^(-k/20)), where FS = 2^(W-1)-1. If no such k exists, the code is 63. Code 0 means 0 dBFS and each step of 1 is 1 dB lower.
- R2: The magnitude is the absolute value of the two's complement sample. The most negative code saturates to FS and so gives code 0.
- R3: While enabled, and with no read of the peak address, the held code never increases. A valid sample replaces it only when the sample's code is smaller.
- R4: While enable is low, samples are ignored and the held code is 63. A peak read in that state returns 63.
- R5: A read with rd_en high and rd_addr = 4'b0101 makes rd_data equal {4'b0000, held code} after the next clock edge. The same edge sets the held code back to 63.
- R6: When a valid sample and a peak read fall in the same cycle, the read returns the code held before that cycle. The held code then becomes the new sample's code, not 63.
- R7: A read at any other address returns rd_data = 0 and leaves the held code unchanged.
- R8: rd_data bits 9:6 are always zero.
- R9: A sample presented with smp_vld low has no effect on the held code.
- R10: A synchronous active-high reset sets the held code to 63 and rd_data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pk_en | input | 1 | Peak tracking enable |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | W (24) | Signed ADC sample |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register address (5 selects the peak) |
| rd_data | output | 10 | Registered read data |

## Verification
A peak read and a new sample can arrive in the same clock cycle. In that cycle the read-and-clear and the min-update both act on the held code. The bench sets up a known held code and then applies a strobe together with a read, where the sample is sometimes louder and sometimes quieter than the held code. It judges the result in two places. The read data must show the old held code, and the next read must show exactly the new sample's code rather than 63 or a merged minimum.

// File: rtl/peak_pkg.sv
package peak_pkg;

    localparam int SAMPLE_W_DEF = 24;
    localparam int CODE_W       = 6;
    localparam int NUM_LVL      = (1 << CODE_W) - 1;   // thresholds for codes 0..62
    localparam int RD_W         = 10;
    localparam int ADDR_W       = 4;
    localparam logic [ADDR_W-1:0] PEAK_ADDR = 4'b0101;
    localparam logic [CODE_W-1:0] CODE_FLOOR = '1;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_PEAK  = 2'd1,
        RD_OTHER = 2'd2
    } rd_kind_e;

    typedef struct packed {
        logic  vld;
        code_t code;
    } lvl_t;

    // ceil(FS * 10^(-k/20)), FS = 2^(w-1)-1, evaluated at elaboration
    function automatic longint thr_of(input int w, input int k);
        real    fs;
        real    x;
        longint t;
        fs = real'((longint'(1) << (w - 1)) - 1);
        x  = fs * (10.0 ** (-real'(k) / 20.0));
        t  = $rtoi(x);
        if (real'(t) < x) t = t + 1;
        return t;
    endfunction

endpackage

// File: rtl/peak_mag.sv
module peak_mag #(
    parameter int W = peak_pkg::SAMPLE_W_DEF
) (
    input  logic signed [W-1:0] smp,
    output logic        [W-2:0] mag
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] neg;

    always_comb begin
        neg = -smp;
        if (smp == MOST_NEG)
            mag = '1;                       // saturate to full scale
        else if (smp[W-1])
            mag = neg[W-2:0];
        else
            mag = smp[W-2:0];
    end
endmodule

// File: rtl/peak_code.sv
module peak_code
    import peak_pkg::*;
#(
    parameter int W = SAMPLE_W_DEF
) (
    input  logic [W-2:0] mag,
    output code_t        code
);
    logic [NUM_LVL-1:0] hit;

    for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
        localparam longint THR_L = thr_of(W, k);
        localparam logic [W-2:0] THR = THR_L[W-2:0];
        assign hit[k] = (mag >= THR);
    end

    // thresholds fall with k, so the hits form a thermometer from the top
    always_comb begin
        code = code_t'(NUM_LVL - $countones(hit));
    end
endmodule

// File: rtl/peak_hold.sv
module peak_hold
    import peak_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  lvl_t  lvl,
    input  logic  clr,
    output code_t held
);
    always_ff @(posedge clk) begin
        if (rst || !en)
            held <= CODE_FLOOR;
        else if (clr)
            held <= lvl.vld ? lvl.code : CODE_FLOOR;
        else if (lvl.vld && lvl.code < held)
            held <= lvl.code;
    end

    logic primed;
    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    // R3
    held_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !clr) |=> (!primed || !en || held <= $past(held)));

    // R4
    disabled_floor_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (held == CODE_FLOOR));

    // R5
    clear_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (en && clr && !lvl.vld) |=> (!en || held == CODE_FLOOR || $past(primed) == 1'b0 || 1'b1) && (held == CODE_FLOOR || !$past(en)));

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && en && !clr && !lvl.vld) |=> $stable(held) || !$past(en));
endmodule

// File: rtl/adc_peak_meter.sv
module adc_peak_meter
    import peak_pkg::*;
#(
    parameter int W = SAMPLE_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pk_en,
    input  logic                 smp_vld,
    input  logic signed [W-1:0]  smp_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [RD_W-1:0]      rd_data
);
    localparam int PAD_W = RD_W - CODE_W;

    logic [W-2:0] mag;
    code_t        code;
    code_t        held;
    lvl_t         lvl;
    rd_kind_e     rk;

    peak_mag  #(.W(W)) u_mag  (.smp(smp_data), .mag(mag));
    peak_code #(.W(W)) u_code (.mag(mag), .code(code));

    always_comb begin
        lvl.vld  = smp_vld;
        lvl.code = code;
        if (!rd_en)                rk = RD_IDLE;
        else if (rd_addr == PEAK_ADDR) rk = RD_PEAK;
        else                       rk = RD_OTHER;
    end

    peak_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .en   (pk_en),
        .lvl  (lvl),
        .clr  (rk == RD_PEAK),
        .held (held)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rk == RD_PEAK)
            rd_data <= {{PAD_W{1'b0}}, held};
        else if (rk == RD_OTHER)
            rd_data <= '0;
    end

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[RD_W-1:CODE_W] == '0);

    // R7
    other_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (rk == RD_OTHER) |=> (rd_data == '0));

    // R2
    most_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_data == {1'b1, {(W-1){1'b0}}}) |-> (code == '0));
endmodule

// File: tb/tb_adc_peak_meter.sv
module tb_adc_peak_meter;
    localparam int W  = 24;
    localparam longint FS = (longint'(1) << (W - 1)) - 1;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                pk_en = 1'b0;
    logic                smp_vld = 1'b0;
    logic signed [W-1:0] smp_data = '0;
    logic                rd_en = 1'b0;
    logic [3:0]          rd_addr = '0;
    logic [9:0]          rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int exp_held = 63;
    longint thr [0:62];

    always #10 clk = ~clk;

    adc_peak_meter #(.W(W)) dut (
        .clk(clk), .rst(rst), .pk_en(pk_en), .smp_vld(smp_vld),
        .smp_data(smp_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic longint mag_of(input longint s);
        if (s == -(FS + 1)) return FS;
        return (s < 0) ? -s : s;
    endfunction

    function automatic int code_of(input longint s);
        longint m;
        m = mag_of(s);
        for (int k = 0; k < 63; k++)
            if (m >= thr[k]) return k;
        return 63;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, sample after posedge
    task automatic cyc(input logic en, input logic v, input longint s,
                       input logic rd, input logic [3:0] a);
        @(negedge clk);
        pk_en = en; smp_vld = v; smp_data = s[W-1:0]; rd_en = rd; rd_addr = a;
        @(posedge clk);
        #5;
        pk_en = en; smp_vld = 1'b0; rd_en = 1'b0;
    endtask

    task automatic peak_read(input string req, input int exp);
        cyc(1'b1, 1'b0, 0, 1'b1, 4'b0101);
        check(req, int'(rd_data), exp);
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 63; k++) begin
            real x;
            x = real'(FS) * $pow(10.0, -real'(k) / 20.0);
            thr[k] = $rtoi(x);
            if (real'(thr[k]) < x) thr[k] = thr[k] + 1;
        end
        repeat (3) @(posedge clk);
        #5;
        check("R10 reset rd_data", int'(rd_data), 0);
        @(negedge clk); rst = 1'b0;

        // R4: disabled read returns floor, samples ignored
        cyc(1'b0, 1'b1, FS, 1'b0, 4'b0);
        cyc(1'b0, 1'b0, 0, 1'b1, 4'b0101);
        check("R4 disabled read", int'(rd_data), 63);

        // R1/R2: every threshold exactly, one below, and negated
        for (int k = 0; k < 63; k++) begin
            cyc(1'b1, 1'b1, thr[k], 1'b0, 4'b0);
            peak_read("R1 exact threshold", k);
            cyc(1'b1, 1'b1, thr[k] - 1, 1'b0, 4'b0);
            peak_read("R1 threshold minus one", code_of(thr[k] - 1));
            cyc(1'b1, 1'b1, -thr[k], 1'b0, 4'b0);
            peak_read("R2 negative threshold", k);
        end
        cyc(1'b1, 1'b1, -(FS + 1), 1'b0, 4'b0);
        peak_read("R2 most negative", 0);
        cyc(1'b1, 1'b1, 0, 1'b0, 4'b0);
        peak_read("R1 zero sample", 63);

        // R3/R9: random sequences, bench model of running minimum
        for (int t = 0; t < 400; t++) begin
            int n;
            exp_held = 63;
            n = 1 + ($urandom % 6);
            for (int i = 0; i < n; i++) begin
                longint s;
                logic v;
                s = longint'($signed(24'($urandom))) >>> ($urandom % 24);
                v = ($urandom % 4) != 0;
                cyc(1'b1, v, s, 1'b0, 4'b0);
                if (v && code_of(s) < exp_held) exp_held = code_of(s);
            end
            peak_read("R3 running minimum", exp_held);
        end
        // R9 explicit: invalid loud sample ignored
        cyc(1'b1, 1'b1, thr[30], 1'b0, 4'b0);
        cyc(1'b1, 1'b0, FS, 1'b0, 4'b0);
        peak_read("R9 invalid ignored", 30);

        // R5: read clears to 63
        peak_read("R5 cleared after read", 63);

        // R7: other address returns zero, no clear
        cyc(1'b1, 1'b1, thr[12], 1'b0, 4'b0);
        for (int a = 0; a < 16; a++) begin
            if (a == 5) continue;
            cyc(1'b1, 1'b0, 0, 1'b1, 4'(a));
            check("R7 other address zero", int'(rd_data), 0);
        end
        peak_read("R7 no clear by other address", 12);

        // R6: read and sample in same cycle (louder and quieter)
        cyc(1'b1, 1'b1, thr[20], 1'b0, 4'b0);
        cyc(1'b1, 1'b1, thr[5], 1'b1, 4'b0101);
        check("R6 old value returned", int'(rd_data), 20);
        peak_read("R6 new sample seeds", 5);
        cyc(1'b1, 1'b1, thr[3], 1'b0, 4'b0);
        cyc(1'b1, 1'b1, thr[40], 1'b1, 4'b0101);
        check("R6 old value returned quieter", int'(rd_data), 3);
        peak_read("R6 quieter seeds", 40);

        // R4: disabling clears state
        cyc(1'b1, 1'b1, thr[2], 1'b0, 4'b0);
        cyc(1'b0, 1'b0, 0, 1'b0, 4'b0);
        peak_read("R4 disable resets held", 63);

        // R8: upper bits zero after a full-scale read
        cyc(1'b1, 1'b1, FS, 1'b0, 4'b0);
        peak_read("R8 full scale", 0);
        check("R8 upper bits", int'(rd_data[9:6]), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule